// File: doc/BRIEF.md
# Slow Crystal Loss Watchdog

This block watches a 32 kHz crystal clock and detects when it has stopped. A second slow clock that is always running, the reference clock, clocks the block. The crystal signal is sampled as data through a two-flop synchronizer. Every transition of the crystal, rising or falling, restarts a count of reference cycles. If the count reaches the programmed timeout before another transition arrives, the block sets a sticky dead-crystal status. It can also raise an interrupt, which has its own enable.

When automatic backup is enabled, the same timeout event moves the registered slow-clock source select from the crystal to the backup clock. No software action is needed, so the switch also happens while the processor is asleep.

Recovery goes in a fixed order. Software clears the enable and restarts the crystal. After the crystal has settled, it sets the enable again. Clearing the enable returns the select to the crystal and clears the status. A software reset level clears the count and all state in the same way.

Top module: `xtal_loss_wdt`

## Requirements
- R1: After reset, dead_o, irq_o and src_sel_o are all 0, where src_sel_o = 0 means crystal and 1 means backup.
- R2: Consider a timeout T in the range 1 to 255, with en_i high, sw_rst_i low and no crystal transition. The count starts from zero. dead_o rises on the T-th reference rising edge that sees those conditions, and not before.
- R3: Every synchronized crystal transition, in either direction, restarts the count from zero. A crystal that toggles every H reference cycles, with H + 3 < T, never raises dead_o.
- R4: Once set, dead_o stays 1 while en_i is high and sw_rst_i is low, even if the crystal resumes toggling. The count saturates and does not wrap at a timeout of 255.
- R5: irq_o is dead_o AND irq_en_i, in the same cycle, with no register in between.
- R6: With auto_bk_i = 1, src_sel_o goes to 1 on the same edge that dead_o rises. With auto_bk_i = 0 at that edge, src_sel_o stays 0. Setting auto_bk_i afterwards has no effect until the next timeout.
- R7: While sw_rst_i is high, the count, dead_o and src_sel_o are held at 0 from the next edge on. After sw_rst_i falls, counting restarts from zero, with the R2 timing.
- R8: With en_i low, nothing is counted, and dead_o and src_sel_o are 0 from the next edge on. Re-enabling with a running crystal keeps dead_o and src_sel_o at 0.
- R9: A timeout value of 0 behaves like a timeout of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference slow clock; clocks all logic |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_clk_i | input | 1 | Monitored crystal clock, sampled as data |
| en_i | input | 1 | Monitoring enable; low clears state |
| sw_rst_i | input | 1 | Software reset level; high clears count and state |
| timeout_i | input | 8 | Timeout in reference cycles (0 acts as 1) |
| auto_bk_i | input | 1 | Switch to the backup clock at timeout |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Dead-crystal interrupt |
| dead_o | output | 1 | Sticky dead-crystal status |
| src_sel_o | output | 1 | Slow-clock source select: 0 crystal, 1 backup |

## Verification
The assertions check, on every cycle, a set of invariants. The status is sticky while monitoring runs. The backup select appears only together with the status and only at its rising edge. Disable and software reset clear both the status and the select. The status never rises below the timeout, or directly after a crystal transition. Only the bench's scenarios can show the rest. This covers the exact cycle of the timeout for small, large and zero values. It also covers a running crystal that never trips, a late auto-backup enable having no effect, the interrupt gating, and the full stop, disable, restart and re-enable recovery sequence.

// File: rtl/xwd_pkg.sv
package xwd_pkg;
  typedef enum logic {
    SRC_XTAL   = 1'b0,
    SRC_BACKUP = 1'b1
  } src_sel_e;

  localparam int unsigned XWD_TMO_W      = 8;
  localparam int unsigned XWD_SYNC_DEPTH = 2;
  localparam int unsigned XWD_RST_DEPTH  = 2;
endpackage

// File: rtl/xwd_rst_sync.sv
module xwd_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[DEPTH-1];
endmodule

// File: rtl/xwd_edge_det.sv
module xwd_edge_det #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic edge_o
);
  logic [DEPTH:0] stage_q;
  logic [DEPTH:0] stage_d;

  // stages 0..DEPTH-1 synchronize, stage DEPTH holds the previous sample
  always_comb begin
    stage_d[0] = async_i;
  end

  for (genvar g = 1; g <= DEPTH; g++) begin : g_shift
    always_comb begin
      stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign edge_o = stage_q[DEPTH] ^ stage_q[DEPTH-1];
endmodule

// File: rtl/xwd_counter.sv
module xwd_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         run_i,
  input  logic         edge_i,
  input  logic         dead_i,
  input  logic [W-1:0] tmo_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W:0]   cnt_plus;
  logic         cnt_en;

  assign cnt_plus = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};

  // a timeout of 0 compares as reached after one cycle, like 1
  assign hit_o = run_i && !edge_i && !dead_i && (cnt_plus >= {1'b0, tmo_i});

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (dead_i) begin
      cnt_en = 1'b0;
    end else if (edge_i) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_plus[W-1:0];
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dead_i && run_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/xwd_status.sv
module xwd_status
  import xwd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_n_i,
  input  logic     run_i,
  input  logic     hit_i,
  input  logic     auto_bk_i,
  output logic     dead_o,
  output src_sel_e sel_o
);
  logic     dead_q;
  logic     dead_d;
  src_sel_e sel_q;
  src_sel_e sel_d;

  always_comb begin
    dead_d = dead_q;
    sel_d  = sel_q;
    if (!run_i) begin
      dead_d = 1'b0;
      sel_d  = SRC_XTAL;
    end else if (hit_i) begin
      dead_d = 1'b1;
      if (auto_bk_i) begin
        sel_d = SRC_BACKUP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dead_q <= 1'b0;
      sel_q  <= SRC_XTAL;
    end else begin
      dead_q <= dead_d;
      sel_q  <= sel_d;
    end
  end

  assign dead_o = dead_q;
  assign sel_o  = sel_q;

  AST_DEAD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dead_q && run_i) |=> dead_q); // R4
  AST_SEL_NEEDS_DEAD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel_q == SRC_BACKUP) |-> dead_q); // R6
  AST_SEL_ONLY_AT_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(sel_q == SRC_BACKUP) |-> $rose(dead_q)); // R6
endmodule

// File: rtl/xtal_loss_wdt.sv
module xtal_loss_wdt
  import xwd_pkg::*;
#(
  parameter int unsigned TMO_W      = XWD_TMO_W,
  parameter int unsigned SYNC_DEPTH = XWD_SYNC_DEPTH,
  parameter int unsigned RST_DEPTH  = XWD_RST_DEPTH
) (
  input  logic             ref_clk_i,
  input  logic             rst_n_i,
  input  logic             xtal_clk_i,
  input  logic             en_i,
  input  logic             sw_rst_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             auto_bk_i,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic             dead_o,
  output logic             src_sel_o
);
  logic             rst_n_sync;
  logic             xedge;
  logic             run;
  logic             hit;
  logic             dead;
  logic [TMO_W-1:0] cnt;
  src_sel_e         sel;

  assign run = en_i && !sw_rst_i;

  xwd_rst_sync #(.DEPTH(RST_DEPTH)) u_rst_sync (
    .clk_i   (ref_clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_sync)
  );

  xwd_edge_det #(.DEPTH(SYNC_DEPTH)) u_edge_det (
    .clk_i   (ref_clk_i),
    .rst_n_i (rst_n_sync),
    .async_i (xtal_clk_i),
    .edge_o  (xedge)
  );

  xwd_counter #(.W(TMO_W)) u_counter (
    .clk_i   (ref_clk_i),
    .rst_n_i (rst_n_sync),
    .run_i   (run),
    .edge_i  (xedge),
    .dead_i  (dead),
    .tmo_i   (timeout_i),
    .cnt_o   (cnt),
    .hit_o   (hit)
  );

  xwd_status u_status (
    .clk_i     (ref_clk_i),
    .rst_n_i   (rst_n_sync),
    .run_i     (run),
    .hit_i     (hit),
    .auto_bk_i (auto_bk_i),
    .dead_o    (dead),
    .sel_o     (sel)
  );

  assign dead_o    = dead;
  assign src_sel_o = sel;
  assign irq_o     = dead && irq_en_i;

  AST_DISABLED_QUIET: assert property (@(posedge ref_clk_i) disable iff (!rst_n_sync)
    !en_i |=> (!dead_o && !src_sel_o)); // R8
  AST_SWRST_CLEARS: assert property (@(posedge ref_clk_i) disable iff (!rst_n_sync)
    sw_rst_i |=> (!dead_o && !src_sel_o)); // R7
  AST_RISE_AT_LIMIT: assert property (@(posedge ref_clk_i) disable iff (!rst_n_sync)
    $rose(dead_o) |-> ({1'b0, cnt} >= {1'b0, $past(timeout_i)})); // R2
  AST_NO_RISE_AFTER_EDGE: assert property (@(posedge ref_clk_i) disable iff (!rst_n_sync)
    $rose(dead_o) |-> !$past(xedge)); // R3
endmodule

// File: tb/xtal_loss_wdt_bench.sv
module xtal_loss_wdt_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       xtal;
  logic       en;
  logic       swr;
  logic [7:0] tmo;
  logic       auto_bk;
  logic       irq_en;
  logic       irq;
  logic       dead;
  logic       sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  xtal_loss_wdt u_xtal_loss_wdt (
    .ref_clk_i  (clk),
    .rst_n_i    (rst_n),
    .xtal_clk_i (xtal),
    .en_i       (en),
    .sw_rst_i   (swr),
    .timeout_i  (tmo),
    .auto_bk_i  (auto_bk),
    .irq_en_i   (irq_en),
    .irq_o      (irq),
    .dead_o     (dead),
    .src_sel_o  (sel)
  );

  typedef struct packed {
    logic [7:0] t;
    logic [7:0] half;
    logic       ab;
    logic       ie;
    logic [9:0] cyc;
    logic       xd;
    logic       xs;
    logic       xi;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'd10,  8'd3,   1'b1, 1'b1, 10'd300, 1'b0, 1'b0, 1'b0},
    '{8'd200, 8'd50,  1'b1, 1'b1, 10'd900, 1'b0, 1'b0, 1'b0},
    '{8'd10,  8'd20,  1'b1, 1'b1, 10'd200, 1'b1, 1'b1, 1'b1},
    '{8'd10,  8'd20,  1'b0, 1'b1, 10'd200, 1'b1, 1'b0, 1'b1},
    '{8'd30,  8'd0,   1'b1, 1'b0, 10'd100, 1'b1, 1'b1, 1'b0},
    '{8'd0,   8'd0,   1'b0, 1'b1, 10'd3,   1'b1, 1'b0, 1'b1},
    '{8'd255, 8'd100, 1'b1, 1'b1, 10'd400, 1'b0, 1'b0, 1'b0},
    '{8'd60,  8'd0,   1'b1, 1'b1, 10'd50,  1'b0, 1'b0, 1'b0}
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic run_xtal(input int half, input int cyc);
    for (int c = 1; c <= cyc; c++) begin
      if (half != 0 && (c % half) == 0) xtal = ~xtal;
      tick();
    end
  endtask

  task automatic rearm(input logic [7:0] t, input logic ab, input logic ie);
    en = 1'b0;
    tick(4);
    tmo     = t;
    auto_bk = ab;
    irq_en  = ie;
    en      = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xtal = 1'b0; en = 1'b0; swr = 1'b0;
    tmo = 8'd200; auto_bk = 1'b0; irq_en = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    chk("R1", "dead after reset", dead, 1'b0);
    chk("R1", "irq after reset", irq, 1'b0);
    chk("R1", "sel after reset", sel, 1'b0);

    // table of scenarios (R2 R3 R5 R6 R9)
    for (int v = 0; v < NV; v++) begin
      rearm(VEC[v].t, VEC[v].ab, VEC[v].ie);
      run_xtal(int'(VEC[v].half), int'(VEC[v].cyc));
      chk("R2/R3 vec", "dead", dead, VEC[v].xd);
      chk("R6 vec", "sel", sel, VEC[v].xs);
      chk("R5 vec", "irq", irq, VEC[v].xi);
    end

    // R2 exact timing, T=5
    rearm(8'd5, 1'b1, 1'b1);
    tick(4);
    chk("R2", "dead after 4 of 5", dead, 1'b0);
    tick();
    chk("R2", "dead after 5 of 5", dead, 1'b1);
    chk("R6", "sel switched at timeout", sel, 1'b1);

    // R4 sticky while crystal resumes
    run_xtal(2, 40);
    chk("R4", "dead sticky with crystal back", dead, 1'b1);
    chk("R4", "sel sticky with crystal back", sel, 1'b1);

    // R2 T=1
    rearm(8'd1, 1'b0, 1'b1);
    tick();
    chk("R2", "dead after 1 of 1", dead, 1'b1);

    // R9 timeout 0
    rearm(8'd0, 1'b0, 1'b1);
    tick();
    chk("R9", "dead after 1 with T=0", dead, 1'b1);

    // R4 saturation at 255
    rearm(8'd255, 1'b1, 1'b1);
    tick(254);
    chk("R2", "dead after 254 of 255", dead, 1'b0);
    tick();
    chk("R2", "dead after 255 of 255", dead, 1'b1);
    tick(300);
    chk("R4", "dead stays, no wrap", dead, 1'b1);

    // R6 late auto enable
    rearm(8'd3, 1'b0, 1'b1);
    tick(3);
    chk("R6", "dead with auto off", dead, 1'b1);
    chk("R6", "sel stays crystal", sel, 1'b0);
    auto_bk = 1'b1;
    tick(10);
    chk("R6", "late auto has no effect", sel, 1'b0);

    // R5 interrupt gating, same cycle
    irq_en = 1'b0;
    #1;
    chk("R5", "irq masked", irq, 1'b0);
    irq_en = 1'b1;
    #1;
    chk("R5", "irq unmasked", irq, 1'b1);
    tick();

    // R7 software reset
    rearm(8'd4, 1'b1, 1'b1);
    tick(6);
    chk("R7", "precondition dead", dead, 1'b1);
    swr = 1'b1;
    tick();
    chk("R7", "dead cleared", dead, 1'b0);
    chk("R7", "sel cleared", sel, 1'b0);
    tick(10);
    chk("R7", "no count while held", dead, 1'b0);
    tmo = 8'd5;
    swr = 1'b0;
    tick(4);
    chk("R7", "restart: 4 of 5", dead, 1'b0);
    tick();
    chk("R7", "restart: 5 of 5", dead, 1'b1);

    // R8 disable and recovery
    chk("R8", "precondition sel backup", sel, 1'b1);
    en = 1'b0;
    tick();
    chk("R8", "dead cleared by disable", dead, 1'b0);
    chk("R8", "sel back to crystal", sel, 1'b0);
    chk("R8", "irq cleared", irq, 1'b0);
    tick(20);
    chk("R8", "disabled never fires", dead, 1'b0);
    tmo = 8'd10;
    en  = 1'b1;
    run_xtal(3, 200);
    chk("R8", "re-enabled running: dead", dead, 1'b0);
    chk("R8", "re-enabled running: sel", sel, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule